// File: doc/BRIEF.md
# Page Access Rights Checker

This block decides whether one memory access to an already translated page may proceed. It receives the user/supervisor and read/write attribute bits from the first-level (directory) entry and from the second-level (table) entry, together with the privilege level of the running code and the direction of the access. The block forms the effective rights of the page and reports a permit or fault verdict.

Each entry's attributes form a two-bit code {us, rw}. The effective code is the numerically smaller of the two codes, which makes it the more restrictive one. Only code running at privilege level 3 is checked against that code. Levels 0, 1 and 2 always receive read and write access. A request strobe yields a registered result one clock later. The result carries a valid flag, a permit flag and the effective code.

Top module: `page_rights_chk`

## Requirements
- R1: After a clock edge with `rst_n` low, `res_valid` is 0.
- R2: `res_valid` is 1 in the cycle after an edge that samples `req_valid`=1, and it is 0 in the cycle after an edge that samples `req_valid`=0.
- R3: `eff_rights` equals the numerically smaller of {dir_us,dir_rw} and {tbl_us,tbl_rw} from the accepted request. For example, 10 combined with 01 gives 01.
- R4: When `cpl` is 0, 1 or 2, `permit` is 1 for reads and for writes, whatever the entry bits are.
- R5: When `cpl` is 3 and the effective us bit (eff_rights[1]) is 0, `permit` is 0 for both reads and writes.
- R6: When `cpl` is 3 and the effective code is 10, reads are permitted and writes (`is_write`=1) fault with `permit`=0.
- R7: When `cpl` is 3 and the effective code is 11, both reads and writes are permitted.
- R8: The result outputs (`permit`, `eff_rights`) hold their values in any cycle that follows an edge without an accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| dir_us | input | 1 | Directory entry user/supervisor bit (entry bit 2) |
| dir_rw | input | 1 | Directory entry read/write bit (entry bit 1) |
| tbl_us | input | 1 | Table entry user/supervisor bit (entry bit 2) |
| tbl_rw | input | 1 | Table entry read/write bit (entry bit 1) |
| cpl | input | 2 | Current privilege level, 0 to 3 |
| is_write | input | 1 | 1 for a write access, 0 for a read |
| res_valid | output | 1 | Result valid, one cycle after the request |
| permit | output | 1 | 1 permits the access, 0 signals a fault |
| eff_rights | output | 2 | Effective {us,rw} code |

## Verification
Each output is registered exactly once, so every result appears in the cycle after the edge that samples its request. The bench drives a request just after a falling edge and lets one rising edge pass. It samples the outputs at the next falling edge, which is one cycle after the strobe. Hold behaviour is checked at a second falling edge with the strobe low, and by then `res_valid` must also have dropped.

// File: rtl/page_rights_chk.sv
module page_rights_chk (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       dir_us,
  input  logic       dir_rw,
  input  logic       tbl_us,
  input  logic       tbl_rw,
  input  logic [1:0] cpl,
  input  logic       is_write,
  output logic       res_valid,
  output logic       permit,
  output logic [1:0] eff_rights
);

  logic [1:0] dir_code, tbl_code, eff_c;
  logic       user_mode, ok_c;

  assign dir_code  = {dir_us, dir_rw};
  assign tbl_code  = {tbl_us, tbl_rw};
  assign eff_c     = (dir_code < tbl_code) ? dir_code : tbl_code;
  assign user_mode = (cpl == 2'd3);

  always_comb begin
    if (!user_mode)      ok_c = 1'b1;
    else if (!eff_c[1])  ok_c = 1'b0;
    else                 ok_c = eff_c[0] | ~is_write;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      permit     <= 1'b0;
      eff_rights <= 2'b00;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        permit     <= ok_c;
        eff_rights <= eff_c;
      end
    end
  end

endmodule

module page_rights_chk_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       dir_us,
  input logic       dir_rw,
  input logic       tbl_us,
  input logic       tbl_rw,
  input logic [1:0] cpl,
  input logic       is_write,
  input logic       res_valid,
  input logic       permit,
  input logic [1:0] eff_rights
);

  logic armed;
  always_ff @(posedge clk) armed <= rst_n;

  assert_reset_clears_R1: assert property (@(posedge clk) !rst_n |=> !res_valid);

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);

  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid);

  assert_not_looser_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (eff_rights <= {$past(dir_us), $past(dir_rw)}) &&
                  (eff_rights <= {$past(tbl_us), $past(tbl_rw)}));

  assert_super_ok_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cpl != 2'd3) |=> permit);

  assert_user_none_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cpl == 2'd3) ##1 !eff_rights[1] |-> !permit);

  assert_ro_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cpl == 2'd3 && is_write && !(dir_rw && tbl_rw)) |=> !permit);

  assert_rw_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cpl == 2'd3 && dir_us && tbl_us && dir_rw && tbl_rw) |=> permit);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !req_valid) |=> $stable(permit) && $stable(eff_rights));

endmodule

bind page_rights_chk page_rights_chk_sva u_sva (.*);

// File: tb/page_rights_chk_tb.sv
module page_rights_chk_tb;
  logic clk = 1'b0;
  logic rst_n, req_valid, dir_us, dir_rw, tbl_us, tbl_rw, is_write;
  logic [1:0] cpl;
  logic res_valid, permit;
  logic [1:0] eff_rights;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  page_rights_chk u_dut (.*);

  // vector: {dir[1:0], tbl[1:0], cpl[1:0], wr, exp_permit, exp_eff[1:0]}
  localparam int NV = 14;
  localparam logic [9:0] VEC [NV] = '{
    {2'b10, 2'b01, 2'd3, 1'b0, 1'b0, 2'b01},  // R3 R5
    {2'b10, 2'b01, 2'd0, 1'b1, 1'b1, 2'b01},  // R4
    {2'b00, 2'b00, 2'd1, 1'b1, 1'b1, 2'b00},  // R4
    {2'b00, 2'b11, 2'd2, 1'b0, 1'b1, 2'b00},  // R4
    {2'b01, 2'b11, 2'd3, 1'b0, 1'b0, 2'b01},  // R5
    {2'b11, 2'b00, 2'd3, 1'b1, 1'b0, 2'b00},  // R5
    {2'b10, 2'b11, 2'd3, 1'b0, 1'b1, 2'b10},  // R6 read
    {2'b11, 2'b10, 2'd3, 1'b1, 1'b0, 2'b10},  // R6 write
    {2'b10, 2'b10, 2'd3, 1'b1, 1'b0, 2'b10},  // R6
    {2'b11, 2'b11, 2'd3, 1'b0, 1'b1, 2'b11},  // R7
    {2'b11, 2'b11, 2'd3, 1'b1, 1'b1, 2'b11},  // R7
    {2'b01, 2'b10, 2'd3, 1'b1, 1'b0, 2'b01},  // R3
    {2'b11, 2'b01, 2'd2, 1'b1, 1'b1, 2'b01},  // R3 R4
    {2'b10, 2'b10, 2'd1, 1'b1, 1'b1, 2'b10}   // R4
  };

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] d, input logic [1:0] t, input logic [1:0] c, input logic w);
    req_valid = 1'b1; {dir_us, dir_rw} = d; {tbl_us, tbl_rw} = t; cpl = c; is_write = w;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b1; dir_us = 1; dir_rw = 1; tbl_us = 1; tbl_rw = 1;
    cpl = 2'd3; is_write = 0;
    repeat (3) @(negedge clk);
    check("R1", {3'b0, res_valid}, 4'b0000);
    req_valid = 1'b0; rst_n = 1'b1;
    @(negedge clk);
    check("R2 idle", {3'b0, res_valid}, 4'b0000);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][9:8], VEC[i][7:6], VEC[i][5:4], VEC[i][3]);
      check($sformatf("R2-R7 vec%0d", i), {res_valid, permit, eff_rights},
            {1'b1, VEC[i][2], VEC[i][1:0]});
    end

    // R8: hold with inputs changing but no strobe
    issue(2'b10, 2'b11, 2'd3, 1'b0);
    dir_us = 0; tbl_us = 0; is_write = 1;
    @(negedge clk);
    check("R8 hold", {res_valid, permit, eff_rights}, 4'b0110);
    check("R2 drop", {3'b0, res_valid}, 4'b0000);

    // R2 back-to-back
    req_valid = 1'b1; {dir_us, dir_rw, tbl_us, tbl_rw} = 4'b1111; cpl = 2'd3; is_write = 1;
    @(negedge clk);
    check("R7 b2b1", {res_valid, permit, eff_rights}, 4'b1111);
    {dir_us, dir_rw} = 2'b00; cpl = 2'd3; is_write = 0;
    @(negedge clk);
    req_valid = 1'b0;
    check("R5 b2b2", {res_valid, permit, eff_rights}, 4'b1000);

    // R1 reset mid-stream
    rst_n = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    check("R1 mid", {3'b0, res_valid}, 4'b0000);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule